// File: doc/BRIEF.md
# CEC Receive Acceptance and Error-Bit Policy

This block sits behind the bit-level decoder of a consumer-electronics-control receiver and makes every frame-level decision on the receive side. When the decoder presents a header byte, the block compares the destination nibble with a bitmap of the logical addresses this device owns. It then decides whether the frame is taken in and whether a positive acknowledge is driven. Broadcast frames use destination 15. They are always taken in and never acknowledged by this device, because on a broadcast a low acknowledge slot means a follower rejects the frame. In full-listen mode, frames for other destinations are also taken in, but nothing is driven on the line for them.

While an accepted frame is in progress, the block takes strobes for payload bytes, end of frame and the three timing errors from the decoder: rising edge too early, period too short, and period too long. For each one it issues single-cycle pulses: stop reception, or request an error bit. Both depend on a small set of configuration bits and on whether the frame is a broadcast. It also maintains sticky status flags that are cleared by writing a one. Waveform sampling and the driving of the error bit itself are left to neighbouring logic.

Top module: `cec_rx_policy`

## Requirements
- R1: After reset, `accept_o`, `ack_drive_o`, `rx_stop_o`, `errbit_req_o` and all `flags_o` bits are 0.
- R2: With `cfg_full_listen`=0, a header with destination d (`hdr_byte[3:0]`, 0..14) produces `accept_o`=1 and `ack_drive_o`=1 one cycle later exactly when `own_map[d]`=1. Otherwise both stay 0. An all-zero map matches nothing.
- R3: With `cfg_full_listen`=1, every header produces `accept_o`=1. `ack_drive_o`=1 only when the destination is an own address.
- R4: Destination 15 is broadcast. It always produces `accept_o`=1 and never `ack_drive_o`, whatever `own_map` holds.
- R5: A rise error in an accepted frame pulses `rx_stop_o` exactly when `cfg_stop_on_rise`=1. On an own-addressed frame it requests an error bit only when `cfg_stop_on_rise` and `cfg_rise_errbit_en` are both 1.
- R6: A long-period error on an own-addressed frame requests an error bit exactly when `cfg_long_errbit_en`=1. A short-period error on an own-addressed frame always requests one. Neither stops reception.
- R7: On a broadcast frame with `cfg_bcast_no_errbit`=0, an error bit is requested on a rise error when `cfg_stop_on_rise`=1, and on every long-period error. A short-period error requests one unless `cfg_full_listen`=1.
- R8: On a broadcast frame with `cfg_bcast_no_errbit`=1, no error bit is ever requested.
- R9: A frame taken in only because of full-listen mode (not own, not broadcast) never requests an error bit. Its stop behaviour still follows R5.
- R10: The accepted header and each of the first 15 payload bytes set the byte flag (`flags_o[1]`). A payload byte beyond the 15th sets the overrun flag (`flags_o[2]`) instead of the byte flag.
- R11: Flags are sticky: bit 0 end of frame, 1 byte, 2 overrun, 3 rise error, 4 short error, 5 long error. A 1 in `flag_clr` clears the matching bit. A set in the same cycle as its clear leaves the bit at 1.
- R12: Strobes and errors outside an accepted frame are ignored: no pulse and no flag. This covers frames that were not accepted, and anything after end of frame or after a stop.
- R13: `frame_end` inside an accepted frame sets `flags_o[0]` and closes the frame. A header followed directly by `frame_end` is a valid ping and sets no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_map | input | 15 | Bit n set: device owns logical address n |
| cfg_full_listen | input | 1 | Take in frames for other destinations without acknowledge |
| cfg_stop_on_rise | input | 1 | Rise error stops reception |
| cfg_rise_errbit_en | input | 1 | Rise error requests error bit (when stopping) |
| cfg_long_errbit_en | input | 1 | Long-period error requests error bit |
| cfg_bcast_no_errbit | input | 1 | Suppress all error bits on broadcast frames |
| hdr_valid | input | 1 | Header byte strobe, starts a frame |
| hdr_byte | input | 8 | Header: initiator in 7:4, destination in 3:0 |
| byte_valid | input | 1 | Payload byte strobe |
| frame_end | input | 1 | End-of-frame strobe |
| err_rise | input | 1 | Rise error from decoder |
| err_short | input | 1 | Short-period error from decoder |
| err_long | input | 1 | Long-period error from decoder |
| flag_clr | input | 6 | Write-one-to-clear for flags |
| accept_o | output | 1 | Frame accepted pulse |
| ack_drive_o | output | 1 | Drive positive acknowledge pulse |
| rx_stop_o | output | 1 | Stop reception pulse |
| errbit_req_o | output | 1 | Error-bit request pulse |
| flags_o | output | 6 | Sticky status flags |

## Verification
The bench builds the block with its defaults: 4-bit addresses and a 15-byte payload limit. With those values, all 16 destinations can be swept against single-bit, multi-bit and empty address maps in both listen modes. All 32 configuration combinations can also be crossed with every error type on own, broadcast and foreign frames. The small payload limit puts the overrun boundary at the 16th byte, which a short loop reaches.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
   localparam int FLAG_N  = 6;
   localparam int FL_END  = 0;
   localparam int FL_BYTE = 1;
   localparam int FL_OVR  = 2;
   localparam int FL_RISE = 3;
   localparam int FL_SHRT = 4;
   localparam int FL_LONG = 5;

   typedef struct packed {
      logic full_listen;
      logic stop_on_rise;
      logic rise_gen;
      logic long_gen;
      logic bcast_quiet;
   } rx_cfg_t;
endpackage

// File: rtl/cec_hdr_match.sv
module cec_hdr_match #(
   parameter int ADDR_W     = 4,
   parameter int BCAST_ADDR = 15
) (
   input  logic [(1<<ADDR_W)-2:0] own_map,
   input  logic [ADDR_W-1:0]      dst,
   input  logic                   full_listen,
   output logic                   bcast,
   output logic                   own,
   output logic                   accept
);
   localparam int OWN_W = (1 << ADDR_W) - 1;

   logic [OWN_W-1:0] hit;

   // one comparator per owned-address slot
   for (genvar g = 0; g < OWN_W; g++) begin : g_slot
      if (g == BCAST_ADDR) begin : g_skip
         assign hit[g] = 1'b0;
      end else begin : g_cmp
         assign hit[g] = own_map[g] && (dst == ADDR_W'(g));
      end
   end

   assign bcast  = (dst == ADDR_W'(BCAST_ADDR));
   assign own    = |hit;
   assign accept = bcast | own | full_listen;
endmodule

// File: rtl/cec_err_policy.sv
module cec_err_policy
   import cec_rx_pkg::*;
(
   input  rx_cfg_t cfg,
   input  logic    frm_bcast,
   input  logic    frm_own,
   input  logic    e_rise,
   input  logic    e_short,
   input  logic    e_long,
   output logic    stop,
   output logic    errbit
);
   logic own_req, bc_req;

   // own-addressed frame: per-error enables
   assign own_req = (e_rise & cfg.stop_on_rise & cfg.rise_gen)
                  | (e_long & cfg.long_gen)
                  | e_short;

   // broadcast: overrides per-error enables
   assign bc_req  = ~cfg.bcast_quiet &
                    ((e_rise & cfg.stop_on_rise)
                   | e_long
                   | (e_short & ~cfg.full_listen));

   assign stop   = e_rise & cfg.stop_on_rise;
   assign errbit = frm_bcast ? bc_req : (frm_own ? own_req : 1'b0);
endmodule

// File: rtl/cec_flag_bank.sv
module cec_flag_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flags_o
);
   for (genvar g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags_o[g] <= 1'b0;
         else        flags_o[g] <= set_i[g] | (flags_o[g] & ~clr_i[g]);
      end

      a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         flags_o[g] && !clr_i[g] |=> flags_o[g]);
      a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[g] |=> flags_o[g]);
      a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
         clr_i[g] && !set_i[g] |=> !flags_o[g]);
   end
endmodule

// File: rtl/cec_rx_policy.sv
module cec_rx_policy
   import cec_rx_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int BCAST_ADDR  = 15,
   parameter int MAX_PAYLOAD = 15
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [(1<<ADDR_W)-2:0] own_map,
   input  logic                   cfg_full_listen,
   input  logic                   cfg_stop_on_rise,
   input  logic                   cfg_rise_errbit_en,
   input  logic                   cfg_long_errbit_en,
   input  logic                   cfg_bcast_no_errbit,
   input  logic                   hdr_valid,
   input  logic [2*ADDR_W-1:0]    hdr_byte,
   input  logic                   byte_valid,
   input  logic                   frame_end,
   input  logic                   err_rise,
   input  logic                   err_short,
   input  logic                   err_long,
   input  logic [FLAG_N-1:0]      flag_clr,
   output logic                   accept_o,
   output logic                   ack_drive_o,
   output logic                   rx_stop_o,
   output logic                   errbit_req_o,
   output logic [FLAG_N-1:0]      flags_o
);
   localparam int CNT_W = $clog2(MAX_PAYLOAD + 1);
   localparam int MAP_W = 1 << ADDR_W;

   initial begin
      assert (BCAST_ADDR >= 0 && BCAST_ADDR < MAP_W) else $error("broadcast address out of range");
      assert (MAX_PAYLOAD > 0) else $error("payload limit must be positive");
   end

   rx_cfg_t cfg;
   assign cfg = '{full_listen: cfg_full_listen, stop_on_rise: cfg_stop_on_rise,
                  rise_gen: cfg_rise_errbit_en, long_gen: cfg_long_errbit_en,
                  bcast_quiet: cfg_bcast_no_errbit};

   logic [ADDR_W-1:0] dst;
   logic [ADDR_W-1:0] unused_initiator;
   assign dst              = hdr_byte[ADDR_W-1:0];
   assign unused_initiator = hdr_byte[2*ADDR_W-1:ADDR_W];

   logic hm_bcast, hm_own, hm_accept;
   cec_hdr_match #(.ADDR_W(ADDR_W), .BCAST_ADDR(BCAST_ADDR)) u_match (
      .own_map(own_map), .dst(dst), .full_listen(cfg_full_listen),
      .bcast(hm_bcast), .own(hm_own), .accept(hm_accept));

   // frame context
   logic             active_q, bcast_q, own_q;
   logic [CNT_W-1:0] cnt_q;
   logic             evt_ok, room, pol_stop, pol_errbit;

   assign evt_ok = active_q & ~hdr_valid;
   assign room   = cnt_q < CNT_W'(MAX_PAYLOAD);

   cec_err_policy u_pol (
      .cfg(cfg), .frm_bcast(bcast_q), .frm_own(own_q),
      .e_rise(err_rise), .e_short(err_short), .e_long(err_long),
      .stop(pol_stop), .errbit(pol_errbit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q     <= 1'b0;
         bcast_q      <= 1'b0;
         own_q        <= 1'b0;
         cnt_q        <= '0;
         accept_o     <= 1'b0;
         ack_drive_o  <= 1'b0;
         rx_stop_o    <= 1'b0;
         errbit_req_o <= 1'b0;
      end else begin
         accept_o     <= hdr_valid & hm_accept;
         ack_drive_o  <= hdr_valid & hm_own;
         rx_stop_o    <= evt_ok & pol_stop;
         errbit_req_o <= evt_ok & pol_errbit;
         if (hdr_valid) begin
            active_q <= hm_accept;
            bcast_q  <= hm_bcast;
            own_q    <= hm_own;
            cnt_q    <= '0;
         end else if (active_q) begin
            if (pol_stop || frame_end) active_q <= 1'b0;
            if (byte_valid && room)    cnt_q    <= cnt_q + 1'b1;
         end
      end
   end

   logic [FLAG_N-1:0] fset;
   always_comb begin
      fset          = '0;
      fset[FL_END]  = evt_ok & frame_end;
      fset[FL_BYTE] = (hdr_valid & hm_accept) | (evt_ok & byte_valid & room);
      fset[FL_OVR]  = evt_ok & byte_valid & ~room;
      fset[FL_RISE] = evt_ok & err_rise;
      fset[FL_SHRT] = evt_ok & err_short;
      fset[FL_LONG] = evt_ok & err_long;
   end

   cec_flag_bank #(.N(FLAG_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(fset), .clr_i(flag_clr), .flags_o(flags_o));

   // assertions
   logic [MAP_W-1:0] map_pad;
   assign map_pad = {1'b0, own_map};

   a_r4_bcast_never_acked: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && dst == ADDR_W'(BCAST_ADDR) |=> !ack_drive_o);
   a_r3_ack_implies_accept: assert property (@(posedge clk) disable iff (!rst_n)
      ack_drive_o |-> accept_o);
   a_r2_foreign_rejected: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && !cfg_full_listen && dst != ADDR_W'(BCAST_ADDR) && !map_pad[dst] |=> !accept_o);
   a_r8_quiet_bcast: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_q && cfg_bcast_no_errbit |=> !errbit_req_o);
   a_r5_stop_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_stop_on_rise && err_rise) |=> !rx_stop_o);
   a_r12_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q && !hdr_valid |=> !rx_stop_o && !errbit_req_o);
   a_r9_foreign_no_errbit: assert property (@(posedge clk) disable iff (!rst_n)
      !bcast_q && !own_q |=> !errbit_req_o);
endmodule

// File: tb/sim_cec_rx_policy.sv
`timescale 1ns/1ps
module sim_cec_rx_policy;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n;
   logic [14:0] own_map;
   logic        c_full, c_stop, c_rgen, c_lgen, c_quiet;
   logic        hdr_valid, byte_valid, frame_end, e_rise, e_short, e_long;
   logic [7:0]  hdr_byte;
   logic [5:0]  flag_clr;
   logic        accept_o, ack_drive_o, rx_stop_o, errbit_req_o;
   logic [5:0]  flags_o;

   cec_rx_policy u0 (
      .clk(clk), .rst_n(rst_n), .own_map(own_map),
      .cfg_full_listen(c_full), .cfg_stop_on_rise(c_stop),
      .cfg_rise_errbit_en(c_rgen), .cfg_long_errbit_en(c_lgen),
      .cfg_bcast_no_errbit(c_quiet), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte),
      .byte_valid(byte_valid), .frame_end(frame_end), .err_rise(e_rise),
      .err_short(e_short), .err_long(e_long), .flag_clr(flag_clr),
      .accept_o(accept_o), .ack_drive_o(ack_drive_o), .rx_stop_o(rx_stop_o),
      .errbit_req_o(errbit_req_o), .flags_o(flags_o));

   int  n_chk = 0, n_fail = 0;
   bit  done = 0;
   logic       k_acc, k_ack, k_stop, k_eb;
   logic [5:0] k_fl;

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic capture();
      @(posedge clk); #1;
      k_acc = accept_o; k_ack = ack_drive_o; k_stop = rx_stop_o;
      k_eb = errbit_req_o; k_fl = flags_o;
   endtask

   task automatic hdr(input logic [3:0] d);
      @(negedge clk);
      hdr_valid = 1'b1; hdr_byte = {4'h3, d};
      capture();
      hdr_valid = 1'b0;
   endtask

   task automatic ev(input logic bv, fe, er, es, el, input logic [5:0] clr);
      @(negedge clk);
      byte_valid = bv; frame_end = fe; e_rise = er; e_short = es; e_long = el; flag_clr = clr;
      capture();
      byte_valid = 0; frame_end = 0; e_rise = 0; e_short = 0; e_long = 0; flag_clr = '0;
   endtask

   function automatic bit map_hit(logic [14:0] m, logic [3:0] d);
      return (d != 4'd15) && m[d];
   endfunction

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; own_map = '0; {c_full, c_stop, c_rgen, c_lgen, c_quiet} = '0;
      hdr_valid = 0; hdr_byte = '0; byte_valid = 0; frame_end = 0;
      e_rise = 0; e_short = 0; e_long = 0; flag_clr = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset outputs", {accept_o, ack_drive_o, rx_stop_o, errbit_req_o}, 0);
      chk("R1 reset flags", flags_o, 0);
      @(negedge clk); rst_n = 1;

      // address sweep: R2, R3, R4, R12, R13
      c_stop = 1; c_rgen = 1; c_lgen = 1; c_quiet = 0;
      for (int f = 0; f < 2; f++) begin
         for (int mi = 0; mi < 18; mi++) begin
            logic [14:0] m;
            m = (mi < 15) ? 15'(1 << mi) : (mi == 15 ? 15'h0000 : (mi == 16 ? 15'h7FFF : 15'h2A55));
            for (int d = 0; d < 16; d++) begin
               bit bc, own, acc;
               c_full = f[0]; own_map = m;
               bc = (d == 15); own = map_hit(m, 4'(d)); acc = bc | own | f[0];
               hdr(4'(d));
               chk(f ? "R3 accept" : "R2 accept", k_acc, acc);
               chk(bc ? "R4 bcast ack" : (f ? "R3 ack" : "R2 ack"), k_ack, own);
               if (acc) begin
                  ev(0, 1, 0, 0, 0, '0);
                  chk("R13 end flag", k_fl[0], 1);
                  chk("R13 ping no overrun", k_fl[2], 0);
                  ev(0, 0, 1, 0, 0, '0);
                  chk("R12 error after end ignored", {k_stop, k_eb, k_fl[3]}, 0);
               end else begin
                  ev(0, 0, 1, 1, 1, '0);
                  chk("R12 rejected frame pulses", {k_stop, k_eb}, 0);
                  chk("R12 rejected frame flags", k_fl, 0);
               end
               ev(0, 0, 0, 0, 0, 6'h3F);
            end
         end
      end

      // error policy sweep: R5..R9
      own_map = 15'h0010;
      for (int c = 0; c < 32; c++) begin
         {c_full, c_stop, c_rgen, c_lgen, c_quiet} = 5'(c);
         for (int kind = 0; kind < 3; kind++) begin
            if (kind == 2 && !c_full) continue;
            for (int e = 0; e < 3; e++) begin
               bit xs, xe;
               xs = (e == 0) && c_stop;
               if (kind == 0)
                  xe = (e == 0) ? (c_stop & c_rgen) : (e == 2 ? c_lgen : 1'b1);
               else if (kind == 1)
                  xe = c_quiet ? 1'b0 : ((e == 0) ? c_stop : (e == 2 ? 1'b1 : !c_full));
               else
                  xe = 1'b0;
               hdr(kind == 0 ? 4'd4 : (kind == 1 ? 4'd15 : 4'd7));
               ev(0, 0, e == 0, e == 1, e == 2, '0);
               chk("R5 stop pulse", k_stop, xs);
               chk(kind == 0 ? (e == 0 ? "R5 own errbit" : "R6 own errbit") :
                   (kind == 1 ? (c_quiet ? "R8 bcast quiet" : "R7 bcast errbit") : "R9 foreign errbit"),
                   k_eb, xe);
               chk("R11 error flag set", k_fl[3 + e], 1);
               if (xs) begin
                  ev(0, 0, 0, 0, 1, '0);
                  chk("R12 after stop ignored", {k_eb, k_fl[5]}, 0);
               end
               ev(0, 1, 0, 0, 0, 6'h3F);
               ev(0, 0, 0, 0, 0, 6'h3F);
            end
         end
      end

      // payload limit: R10
      {c_full, c_stop, c_rgen, c_lgen, c_quiet} = '0;
      hdr(4'd4);
      chk("R10 header sets byte flag", k_fl[1], 1);
      for (int b = 1; b <= 15; b++) begin
         ev(0, 0, 0, 0, 0, 6'h02);
         ev(1, 0, 0, 0, 0, '0);
         chk("R10 payload byte flag", k_fl[1], 1);
         chk("R10 no overrun within limit", k_fl[2], 0);
      end
      ev(0, 0, 0, 0, 0, 6'h02);
      ev(1, 0, 0, 0, 0, '0);
      chk("R10 overrun on 16th byte", k_fl[2], 1);
      chk("R10 16th byte not counted", k_fl[1], 0);

      // clear semantics: R11
      ev(0, 0, 0, 0, 1, '0);
      chk("R11 long flag set", k_fl[5], 1);
      ev(0, 0, 0, 0, 1, 6'h20);
      chk("R11 set wins over clear", k_fl[5], 1);
      ev(0, 0, 0, 0, 0, 6'h20);
      chk("R11 clear long", k_fl[5], 0);
      chk("R11 other flags kept", k_fl[2], 1);
      ev(0, 0, 0, 0, 0, '0);
      chk("R11 stays cleared", k_fl[5], 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule